// File: doc/BRIEF.md
# Plasma Subfield Drive Sequencer

This block produces the digital timing skeleton for a plasma panel frame that is split into binary-weighted subfields. A single pulse on `frame_start` launches a frame of `NUM_SF` subfields. Each subfield always runs three phases in a fixed order. First comes a reset phase in which every line is driven together. Next comes an address scan that selects one line at a time, from line 0 to the last line. Last comes a sustain phase in which the whole screen is driven again, and its length is set by the bit weight of the subfield.

The address period (reset plus scan) has the same length in every subfield. The sustain period of subfield `n` lasts `SUST_UNIT << n` clocks, so the eight subfields carry sample bits 0 to 7 with weights 1 to 128. One-cycle strobes mark the first cycle of every phase and of every scanned line, so that a downstream row loader can latch its next row. The line count, the clocks per line, the reset length and the sustain unit are parameters.

The sequencer produces no analog drive levels and handles no pixel data. It outputs only the phase code, the line select (as a one-hot vector and as an index), the subfield index and the strobes.

Top module: `plasma_sf_seq`

## Requirements
- R1: While `rst` is high, and after it is released with no `frame_start`, the outputs show idle: `phase`=0, `line_sel`=0, `sf_idx`=0, and `sustain_en`, `drive_all`, `line_start` and `phase_start` are all 0.
- R2: If `frame_start` is high at a clock edge while the block is idle, then from the next cycle `phase`=1 (reset phase), `sf_idx`=0 and `phase_start`=1 for one cycle.
- R3: Within each subfield the phases follow the order reset (code 1), scan (code 2), sustain (code 3). `phase_start` is high in exactly the first cycle of each phase.
- R4: The reset phase lasts `INIT_CYC` cycles. `drive_all` is high during every reset-phase cycle and every sustain cycle, and low at all other times.
- R5: The scan phase visits lines 0 to `NUM_LINES`-1 in increasing order, `LINE_CYC` cycles each. While line i is scanned, `line_idx`=i and `line_sel` has only bit i set.
- R6: `line_start` is high in exactly the first cycle of each scanned line, and in no other cycle.
- R7: The sustain phase of subfield n lasts `SUST_UNIT << n` cycles. `sustain_en` is high in exactly those cycles.
- R8: `sf_idx` starts at 0 and rises by one at each transition from sustain to reset phase. The address period length does not depend on `sf_idx`.
- R9: When the sustain of subfield `NUM_SF`-1 ends, the block returns to idle in the following cycle with `sf_idx`=0.
- R10: `frame_start` has no effect while `phase` is not 0. This includes the last sustain cycle of a frame: the cycle after it is idle.
- R11: `line_sel` is all zero in every cycle whose phase is not scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Request to run one frame; sampled only while idle |
| phase | output | 2 | 0 idle, 1 reset phase, 2 scan, 3 sustain |
| drive_all | output | 1 | All lines driven together (reset phase or sustain) |
| line_sel | output | NUM_LINES | One-hot select of the scanned line, zero outside scan |
| line_idx | output | LINE_W | Index of the scanned line, meaningful during scan |
| line_start | output | 1 | One-cycle strobe on the first cycle of each scanned line |
| phase_start | output | 1 | One-cycle strobe on the first cycle of each phase |
| sf_idx | output | SF_W | Current subfield, equal to the sample bit being shown |
| sustain_en | output | 1 | High for the whole sustain period |

## Verification
Every output comes from registers updated on the same edge. The first frame cycle therefore appears one clock after the edge that samples `frame_start`, and each later step appears exactly one clock after the edge that ends the previous interval. The bench drives the request on a falling edge and checks at every later falling edge. It compares the outputs against a cycle offset `k` from that first cycle, which it decomposes arithmetically into subfield, phase, line and position within the line. Ignored requests are placed at chosen offsets, including the last sustain cycle. The trace must stay exactly on the undisturbed schedule and must be idle one clock after the frame ends.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_INIT = 2'd1,
        PH_SCAN = 2'd2,
        PH_SUST = 2'd3
    } sfs_phase_e;

    // Index width that never collapses to zero bits.
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Counter width able to hold (largest interval - 1).
    function automatic int cnt_bits(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return (m > 1) ? $clog2(m) : 1;
    endfunction

    // Sustain length of the largest subfield.
    function automatic int top_sustain(input int unit, input int nsf);
        return unit << (nsf - 1);
    endfunction

endpackage

// File: rtl/sfs_interval_timer.sv
module sfs_interval_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    AST_TMR_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);  // R4
    AST_TMR_REST_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> cnt_q == '0);  // R9

endmodule

// File: rtl/sfs_line_decode.sv
module sfs_line_decode #(
    parameter int NUM_LINES = 480,
    parameter int LINE_W    = 9
) (
    input  logic              en,
    input  logic [LINE_W-1:0] idx,
    output logic [NUM_LINES-1:0] sel
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign sel[i] = en && (idx == LINE_W'(i));
    end
endmodule

// File: rtl/sfs_phase_fsm.sv
module sfs_phase_fsm
    import sfs_pkg::*;
#(
    parameter int NUM_LINES = 480,
    parameter int NUM_SF    = 8,
    parameter int LINE_CYC  = 100,
    parameter int INIT_CYC  = 500,
    parameter int SUST_UNIT = 100,
    parameter int LINE_W    = 9,
    parameter int SF_W      = 3,
    parameter int CNT_W     = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output sfs_phase_e        phase_q,
    output logic [LINE_W-1:0] line_q,
    output logic [SF_W-1:0]   sf_q,
    output logic              phase_start_q,
    output logic              line_start_q
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(NUM_LINES - 1);
    localparam logic [SF_W-1:0]   LAST_SF   = SF_W'(NUM_SF - 1);
    localparam logic [CNT_W-1:0]  INIT_M1   = CNT_W'(INIT_CYC - 1);
    localparam logic [CNT_W-1:0]  LINE_M1   = CNT_W'(LINE_CYC - 1);

    sfs_phase_e        phase_d;
    logic [LINE_W-1:0] line_d;
    logic [SF_W-1:0]   sf_d;
    logic              ps_d, ls_d;
    logic [CNT_W-1:0]  sust_m1;

    assign sust_m1 = (CNT_W'(SUST_UNIT) << sf_q) - CNT_W'(1);

    always_comb begin
        phase_d  = phase_q;
        line_d   = line_q;
        sf_d     = sf_q;
        ps_d     = 1'b0;
        ls_d     = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (phase_q)
            PH_IDLE: begin
                if (frame_start) begin
                    phase_d  = PH_INIT;
                    sf_d     = '0;
                    ps_d     = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = INIT_M1;
                end
            end
            PH_INIT: begin
                if (tmr_zero) begin
                    phase_d  = PH_SCAN;
                    line_d   = '0;
                    ps_d     = 1'b1;
                    ls_d     = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = LINE_M1;
                end
            end
            PH_SCAN: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (line_q == LAST_LINE) begin
                        phase_d = PH_SUST;
                        ps_d    = 1'b1;
                        tmr_val = sust_m1;
                    end else begin
                        line_d  = line_q + 1'b1;
                        ls_d    = 1'b1;
                        tmr_val = LINE_M1;
                    end
                end
            end
            PH_SUST: begin
                if (tmr_zero) begin
                    if (sf_q == LAST_SF) begin
                        phase_d = PH_IDLE;
                        sf_d    = '0;
                    end else begin
                        phase_d  = PH_INIT;
                        sf_d     = sf_q + 1'b1;
                        ps_d     = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = INIT_M1;
                    end
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q       <= PH_IDLE;
            line_q        <= '0;
            sf_q          <= '0;
            phase_start_q <= 1'b0;
            line_start_q  <= 1'b0;
        end else begin
            phase_q       <= phase_d;
            line_q        <= line_d;
            sf_q          <= sf_d;
            phase_start_q <= ps_d;
            line_start_q  <= ls_d;
        end
    end

    AST_SCAN_AFTER_INIT: assert property (@(posedge clk) disable iff (rst)
        (phase_start_q && phase_q == PH_SCAN) |-> $past(phase_q) == PH_INIT);  // R3
    AST_SUST_AFTER_SCAN: assert property (@(posedge clk) disable iff (rst)
        (phase_start_q && phase_q == PH_SUST) |-> $past(phase_q) == PH_SCAN);  // R3
    AST_INIT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (phase_start_q && phase_q == PH_INIT) |->
        ($past(phase_q) == PH_IDLE || $past(phase_q) == PH_SUST));  // R3
    AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
        (line_start_q && !phase_start_q) |-> line_q == $past(line_q) + 1'b1);  // R5
    AST_SF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!(phase_start_q && phase_q == PH_INIT) && phase_q != PH_IDLE) |-> $stable(sf_q));  // R8
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && frame_start) |=>
        !(phase_start_q && phase_q == PH_INIT && sf_q == '0));  // R10

endmodule

// File: rtl/plasma_sf_seq.sv
module plasma_sf_seq
    import sfs_pkg::*;
#(
    parameter int NUM_LINES = 480,
    parameter int NUM_SF    = 8,
    parameter int LINE_CYC  = 100,
    parameter int INIT_CYC  = 500,
    parameter int SUST_UNIT = 100,
    localparam int LINE_W   = idx_bits(NUM_LINES),
    localparam int SF_W     = idx_bits(NUM_SF)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_start,
    output logic [1:0]           phase,
    output logic                 drive_all,
    output logic [NUM_LINES-1:0] line_sel,
    output logic [LINE_W-1:0]    line_idx,
    output logic                 line_start,
    output logic                 phase_start,
    output logic [SF_W-1:0]      sf_idx,
    output logic                 sustain_en
);
    localparam int CNT_W = cnt_bits(INIT_CYC, LINE_CYC, top_sustain(SUST_UNIT, NUM_SF));

    logic              tmr_load, tmr_zero;
    logic [CNT_W-1:0]  tmr_val;
    sfs_phase_e        phase_q;
    logic [LINE_W-1:0] line_q;
    logic [SF_W-1:0]   sf_q;
    logic              ps_q, ls_q;

    sfs_phase_fsm #(
        .NUM_LINES(NUM_LINES), .NUM_SF(NUM_SF), .LINE_CYC(LINE_CYC),
        .INIT_CYC(INIT_CYC), .SUST_UNIT(SUST_UNIT),
        .LINE_W(LINE_W), .SF_W(SF_W), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .phase_q(phase_q), .line_q(line_q), .sf_q(sf_q),
        .phase_start_q(ps_q), .line_start_q(ls_q)
    );

    sfs_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    sfs_line_decode #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_dec (
        .en(phase_q == PH_SCAN), .idx(line_q), .sel(line_sel)
    );

    assign phase       = phase_q;
    assign drive_all   = (phase_q == PH_INIT) || (phase_q == PH_SUST);
    assign line_idx    = line_q;
    assign line_start  = ls_q;
    assign phase_start = ps_q;
    assign sf_idx      = sf_q;
    assign sustain_en  = (phase_q == PH_SUST);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd2) |-> $countones(line_sel) == 1);  // R5
    AST_SEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'd2) |-> line_sel == '0);  // R11
    AST_SUST_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(sustain_en) |-> phase_start);  // R7
    AST_LINE_STROBE_SCAN: assert property (@(posedge clk) disable iff (rst)
        line_start |-> phase == 2'd2);  // R6

endmodule

// File: tb/plasma_sf_seq_test.sv
module plasma_sf_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 5;
    localparam int NS = 8;
    localparam int LC = 3;
    localparam int IC = 4;
    localparam int SU = 2;
    localparam int FRAME = NS * (IC + NL * LC) + SU * ((1 << NS) - 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 1'b0;
    logic [1:0] phase;
    logic drive_all, line_start, phase_start, sustain_en;
    logic [NL-1:0] line_sel;
    logic [2:0] line_idx;
    logic [2:0] sf_idx;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    plasma_sf_seq #(
        .NUM_LINES(NL), .NUM_SF(NS), .LINE_CYC(LC), .INIT_CYC(IC), .SUST_UNIT(SU)
    ) uut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .phase(phase),
        .drive_all(drive_all), .line_sel(line_sel), .line_idx(line_idx),
        .line_start(line_start), .phase_start(phase_start), .sf_idx(sf_idx),
        .sustain_en(sustain_en)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, got, exp, $time);
        end
    endtask

    // Expected values at cycle offset k from the first frame cycle.
    int e_ph, e_sf, e_line, e_ls, e_ps;
    task automatic expect_at(input int k);
        int off;
        off = k;
        e_ph = 0; e_sf = 0; e_line = 0; e_ls = 0; e_ps = 0;
        for (int s = 0; s < NS; s++) begin
            if (off < IC) begin
                e_ph = 1; e_sf = s; e_ps = (off == 0); return;
            end
            off -= IC;
            if (off < NL * LC) begin
                e_ph = 2; e_sf = s; e_line = off / LC;
                e_ls = (off % LC == 0); e_ps = (off == 0); return;
            end
            off -= NL * LC;
            if (off < (SU << s)) begin
                e_ph = 3; e_sf = s; e_ps = (off == 0); return;
            end
            off -= (SU << s);
        end
    endtask

    task automatic check_cycle(input int k);
        expect_at(k);
        chk("R3 phase", phase, e_ph);
        chk("R8 sf_idx", sf_idx, e_sf);
        chk("R3 phase_start", phase_start, e_ps);
        chk("R6 line_start", line_start, e_ls);
        chk("R7 sustain_en", sustain_en, e_ph == 3);
        chk("R4 drive_all", drive_all, (e_ph == 1 || e_ph == 3));
        if (e_ph == 2) begin
            chk("R5 line_idx", line_idx, e_line);
            chk("R5 line_sel", line_sel, 1 << e_line);
        end else begin
            chk("R11 line_sel", line_sel, 0);
        end
    endtask

    task automatic check_idle(input string tag);
        chk({tag, " phase"}, phase, 0);
        chk({tag, " line_sel"}, line_sel, 0);
        chk({tag, " sf_idx"}, sf_idx, 0);
        chk({tag, " sustain_en"}, sustain_en, 0);
        chk({tag, " drive_all"}, drive_all, 0);
        chk({tag, " strobes"}, {line_start, phase_start}, 0);
    endtask

    // One frame; frame_start re-pulsed at offsets inj_a and inj_b (R10).
    task automatic run_frame(input int inj_a, input int inj_b);
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        for (int k = 0; k <= FRAME + 3; k++) begin
            if (k >= FRAME) check_idle("R9 R10 end");
            else            check_cycle(k);
            frame_start = (k == inj_a || k == inj_b);
            @(negedge clk);
        end
        frame_start = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog R9: got running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check_idle("R1 after reset");

        // R2 start, plain frame
        run_frame(-1, -1);
        // R10 requests mid-init and during the last sustain cycle
        run_frame(2, FRAME - 1);
        // R10 requests at a line boundary and inside a long sustain
        run_frame(IC + LC, 300);

        // R1 reset mid-frame
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        repeat (50) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R1 mid-frame reset");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 release");

        // R2 restart after reset
        run_frame(-1, -1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule